// File: doc/BRIEF.md
# Multi-bit shift and rotate execution unit

This execution unit takes one register operand and moves its bits one to four places in a single operation. It can rotate right through the carry, shift right arithmetically, shift right logically, or shift left arithmetically. The operand is 20 bits wide, or 16 bits wide with the upper four bits forced to zero. The count arrives as a two-bit field that holds the number of places minus one. The unit then runs one serial step per clock cycle until the count is used up.

Operations enter on a valid/ready input channel. The unit takes a new operation only when it is idle, so `in_ready` is low while it is stepping and while it holds a result. A result leaves on a valid/ready output channel. Once `out_valid` rises, the result and flags stay stable until the cycle in which `out_ready` is high. The unit returns to idle on the edge that completes that handshake. `out_ready` may be held low for any number of cycles.

The unit produces the result, the carry, and the zero and negative flags. The flags are taken at the selected width.

Top module: `shift_rot_unit`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A count field value k performs k+1 steps. The operation is accepted on the edge where `in_valid` and `in_ready` are both high. `out_valid` rises right after the (k+1)-th clock edge that follows the accepting edge.
- R3: Op code 2'b00 rotates right through carry. Each step moves the carry into the top bit of the selected width, and bit 0 becomes the new carry.
- R4: Op code 2'b01 is an arithmetic right shift. The top bit of the selected width keeps its value, and bit 0 becomes the carry.
- R5: Op code 2'b10 is an arithmetic left shift. A zero enters bit 0, and the top bit of the selected width becomes the carry.
- R6: Op code 2'b11 is a logical right shift. A zero enters the top bit of the selected width, and bit 0 becomes the carry.
- R7: `in_wide`=1 selects 20-bit data, with the top bit at 19. `in_wide`=0 selects 16-bit data, with the top bit at 15. In 16-bit mode, operand bits 19:16 are ignored and result bits 19:16 are 0.
- R8: `out_carry` is the last bit shifted out. `out_zero` is 1 exactly when the result is zero at the selected width. `out_neg` is the top bit of the result at the selected width.
- R9: While `out_valid` is 1 and `out_ready` is 0, the result and flags hold steady. Inputs offered while `in_ready` is 0 are not captured and start no operation.
- R10: The fields of instruction word 0x0845 map onto the inputs as follows: bits 11:10 give the count field (2), bits 9:8 give the op code (00), and bit 4 equal to 0 selects 20-bit data. With these inputs the unit rotates a 20-bit value right through carry three times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit idle, operation will be taken |
| in_operand | input | DATA_W | Operand value |
| in_carry | input | 1 | Carry flag in |
| in_op | input | 2 | Operation code |
| in_count | input | CNT_W | Number of places minus one |
| in_wide | input | 1 | 1 = 20-bit data, 0 = 16-bit data |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | DATA_W | Shifted or rotated value |
| out_carry | output | 1 | Carry out |
| out_zero | output | 1 | Result is zero at the selected width |
| out_neg | output | 1 | Top bit of the result at the selected width |

## Verification
The bench builds the unit with its defaults: DATA_W=20, NARROW_W=16 and CNT_W=2. With these values every count from one to four places can be reached, with both widths and all four op codes. A sweep covers the full op × count × width grid with varied operands. A directed case checks the 16-bit mode against operands whose upper bits are set, so ignoring those bits is actually tested.

// File: rtl/sru_pkg.sv
package sru_pkg;
  localparam int OP_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_RRC = 2'b00,
    OP_RRA = 2'b01,
    OP_RLA = 2'b10,
    OP_RRU = 2'b11
  } sru_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_BUSY = 2'b01,
    ST_HOLD = 2'b10
  } sru_state_e;
endpackage

// File: rtl/sru_step_core.sv
module sru_step_core
  import sru_pkg::*;
#(
  parameter int W = 20
) (
  input  logic [W-1:0]  x,
  input  logic          c,
  input  sru_op_e       op,
  output logic [W-1:0]  y,
  output logic          co
);
  always_comb begin
    y  = '0;
    co = x[0];
    unique case (op)
      OP_RRC: y = {c, x[W-1:1]};
      OP_RRA: y = {x[W-1], x[W-1:1]};
      OP_RRU: y = {1'b0, x[W-1:1]};
      OP_RLA: begin
        y  = {x[W-2:0], 1'b0};
        co = x[W-1];
      end
      default: y = x;
    endcase
  end
endmodule

// File: rtl/sru_step.sv
module sru_step
  import sru_pkg::*;
#(
  parameter int DATA_W   = 20,
  parameter int NARROW_W = 16
) (
  input  logic [DATA_W-1:0] x,
  input  logic              c,
  input  sru_op_e           op,
  input  logic              wide,
  output logic [DATA_W-1:0] y,
  output logic              co
);
  logic [DATA_W-1:0] y_arr [2];
  logic              co_arr [2];

  for (genvar g = 0; g < 2; g++) begin : g_width
    localparam int GW = (g == 1) ? DATA_W : NARROW_W;
    logic [GW-1:0] yg;
    sru_step_core #(.W(GW)) u_core (
      .x  (x[GW-1:0]),
      .c  (c),
      .op (op),
      .y  (yg),
      .co (co_arr[g])
    );
    assign y_arr[g] = DATA_W'(yg);
  end

  assign y  = wide ? y_arr[1]  : y_arr[0];
  assign co = wide ? co_arr[1] : co_arr[0];
endmodule

// File: rtl/sru_flags.sv
module sru_flags #(
  parameter int DATA_W   = 20,
  parameter int NARROW_W = 16
) (
  input  logic [DATA_W-1:0] r,
  input  logic              wide,
  output logic              zero,
  output logic              neg
);
  always_comb begin
    if (wide) begin
      zero = (r == '0);
      neg  = r[DATA_W-1];
    end else begin
      zero = (r[NARROW_W-1:0] == '0);
      neg  = r[NARROW_W-1];
    end
  end
endmodule

// File: rtl/sru_ctrl.sv
module sru_ctrl
  import sru_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  input  logic [CNT_W-1:0] count,
  output logic             in_ready,
  output logic             out_valid,
  output logic             load,
  output logic             step
);
  localparam int TRK_W = CNT_W + 2;

  sru_state_e       state_q;
  logic [CNT_W-1:0] rem_q;

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_HOLD);
  assign load      = in_ready && in_valid;
  assign step      = (state_q == ST_BUSY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (in_valid) begin
          state_q <= ST_BUSY;
          rem_q   <= count;
        end
        ST_BUSY: begin
          if (rem_q == '0) state_q <= ST_HOLD;
          else             rem_q   <= rem_q - 1'b1;
        end
        ST_HOLD: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Independent tally of the steps taken since the last accept.
  logic [TRK_W-1:0] trk_steps_q;
  logic [TRK_W-1:0] trk_want_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_steps_q <= '0;
      trk_want_q  <= '0;
    end else if (load) begin
      trk_steps_q <= '0;
      trk_want_q  <= TRK_W'(count) + 1'b1;
    end else if (step) begin
      trk_steps_q <= trk_steps_q + 1'b1;
    end
  end

  assert_step_total_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (trk_steps_q == trk_want_q));

  assert_accept_drops_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_ready_valid_apart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_ready, out_valid, step}));
endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
  import sru_pkg::*;
#(
  parameter int DATA_W   = 20,
  parameter int NARROW_W = 16,
  parameter int CNT_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_operand,
  input  logic              in_carry,
  input  logic [OP_W-1:0]   in_op,
  input  logic [CNT_W-1:0]  in_count,
  input  logic              in_wide,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_carry,
  output logic              out_zero,
  output logic              out_neg
);
  logic              load, step;
  logic [DATA_W-1:0] val_q, val_d;
  logic              c_q, c_d;
  sru_op_e           op_q;
  logic              wide_q;

  sru_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .count     (in_count),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .load      (load),
    .step      (step)
  );

  sru_step #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_step (
    .x    (val_q),
    .c    (c_q),
    .op   (op_q),
    .wide (wide_q),
    .y    (val_d),
    .co   (c_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      c_q    <= 1'b0;
      op_q   <= OP_RRC;
      wide_q <= 1'b1;
    end else if (load) begin
      val_q  <= in_wide ? in_operand : DATA_W'(in_operand[NARROW_W-1:0]);
      c_q    <= in_carry;
      op_q   <= sru_op_e'(in_op);
      wide_q <= in_wide;
    end else if (step) begin
      val_q <= val_d;
      c_q   <= c_d;
    end
  end

  sru_flags #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_flags (
    .r    (val_q),
    .wide (wide_q),
    .zero (out_zero),
    .neg  (out_neg)
  );

  assign out_result = val_q;
  assign out_carry  = c_q;

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_carry)));

  assert_narrow_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !wide_q) |-> (out_result[DATA_W-1:NARROW_W] == '0));

  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zero) |-> (out_result[NARROW_W-1:0] == '0));
endmodule

// File: tb/sim_shift_rot_unit.sv
module sim_shift_rot_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [19:0] in_operand = '0;
  logic        in_carry = 1'b0;
  logic [1:0]  in_op = '0;
  logic [1:0]  in_count = '0;
  logic        in_wide = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [19:0] out_result;
  logic        out_carry, out_zero, out_neg;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_rot_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_carry(in_carry), .in_op(in_op),
    .in_count(in_count), .in_wide(in_wide), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_carry(out_carry),
    .out_zero(out_zero), .out_neg(out_neg)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Expected behaviour from the requirements: returns {neg, zero, carry, value}.
  function automatic logic [22:0] ref_model(input logic [1:0] op, input int cnt, input bit wide,
                                            input logic [19:0] x, input logic c);
    int w;
    logic [19:0] v;
    logic cc;
    w  = wide ? 20 : 16;
    v  = wide ? x : {4'b0, x[15:0]};
    cc = c;
    for (int i = 0; i <= cnt; i++) begin
      logic lsb, msb;
      lsb = v[0];
      msb = v[w-1];
      case (op)
        2'b00: begin v = v >> 1; v[w-1] = cc;  cc = lsb; end
        2'b01: begin v = v >> 1; v[w-1] = msb; cc = lsb; end
        2'b11: begin v = v >> 1;               cc = lsb; end
        default: begin v = v << 1; cc = msb; if (!wide) v[19:16] = 4'b0; end
      endcase
    end
    return {v[w-1], wide ? (v == 20'd0) : (v[15:0] == 16'd0), cc, v};
  endfunction

  task automatic run_case(input string req, input logic [1:0] op, input logic [1:0] cnt,
                          input bit wide, input logic [19:0] x, input logic c);
    logic [22:0] e;
    int lat;
    e = ref_model(op, int'(cnt), wide, x, c);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_count = cnt; in_wide = wide;
    in_operand = x; in_carry = c;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk("R2", "latency", lat, int'(cnt) + 1);
    chk(req, "result", out_result, e[19:0]);
    chk("R8", "carry", out_carry, e[20]);
    chk("R8", "zero", out_zero, e[21]);
    chk("R8", "neg", out_neg, e[22]);
    @(negedge clk);
    chk("R9", "idle after handshake", {out_valid, in_ready}, 2'b01);
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "in_ready/out_valid in reset", {in_ready, out_valid}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "in_ready/out_valid after reset", {in_ready, out_valid}, 2'b10);
  endtask

  task automatic test_instr_word;
    logic [15:0] iw;
    iw = 16'h0845;
    run_case("R10", iw[9:8], iw[11:10], ~iw[4], 20'h12345, 1'b1);
    chk("R10", "fixed result", out_result, 20'h62468);
    chk("R3", "fixed carry", out_carry, 1'b1);
  endtask

  task automatic test_ops;
    run_case("R3", 2'b00, 2'd0, 1'b1, 20'h00001, 1'b1);
    chk("R3", "carry into bit19", out_result, 20'h80000);
    run_case("R4", 2'b01, 2'd3, 1'b1, 20'h80000, 1'b0);
    chk("R4", "sign kept", out_result, 20'hF8000);
    run_case("R5", 2'b10, 2'd1, 1'b1, 20'hC0001, 1'b0);
    chk("R5", "left shift", out_result, 20'h00004);
    run_case("R6", 2'b11, 2'd3, 1'b1, 20'hFFFFF, 1'b1);
    chk("R6", "zeros in top", out_result, 20'h0FFFF);
    run_case("R4", 2'b01, 2'd2, 1'b0, 20'h08000, 1'b0);
    chk("R4", "narrow sign at bit15", out_result, 20'h0F000);
  endtask

  task automatic test_narrow;
    run_case("R7", 2'b11, 2'd0, 1'b0, 20'hF8001, 1'b0);
    chk("R7", "upper ignored", out_result, 20'h04000);
    run_case("R7", 2'b00, 2'd0, 1'b0, 20'hF0001, 1'b1);
    chk("R7", "carry enters bit15", out_result, 20'h08000);
    run_case("R7", 2'b10, 2'd0, 1'b0, 20'h08000, 1'b0);
    chk("R7", "bit15 out as carry", {out_carry, out_zero}, 2'b11);
    run_case("R8", 2'b10, 2'd0, 1'b0, 20'h04000, 1'b0);
    chk("R8", "neg at bit15", out_neg, 1'b1);
  endtask

  task automatic test_backpressure;
    logic [22:0] e;
    e = ref_model(2'b01, 1, 1'b1, 20'hA5A5A, 1'b0);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 2'b01; in_count = 2'd1; in_wide = 1'b1;
    in_operand = 20'hA5A5A; in_carry = 1'b0;
    @(negedge clk);
    in_operand = 20'h00000; in_op = 2'b11; in_count = 2'd3;
    repeat (4) @(negedge clk);
    chk("R9", "holding, ready low", {out_valid, in_ready}, 2'b10);
    chk("R9", "held result", out_result, e[19:0]);
    repeat (3) @(negedge clk);
    chk("R9", "still held", out_result, e[19:0]);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9", "released", {out_valid, in_ready}, 2'b01);
    repeat (5) @(negedge clk);
    chk("R9", "no phantom operation", {out_valid, in_ready}, 2'b01);
  endtask

  task automatic test_sweep;
    logic [19:0] lfsr;
    lfsr = 20'h5B3C7;
    for (int op = 0; op < 4; op++)
      for (int cn = 0; cn < 4; cn++)
        for (int wd = 0; wd < 2; wd++) begin
          lfsr = {lfsr[18:0], lfsr[19] ^ lfsr[16]};
          run_case(op == 0 ? "R3" : op == 1 ? "R4" : op == 2 ? "R5" : "R6",
                   2'(op), 2'(cn), wd[0], lfsr, lfsr[7]);
        end
  endtask

  initial begin
    test_reset();
    test_instr_word();
    test_ops();
    test_narrow();
    test_backpressure();
    test_sweep();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule